// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter (I2S and MSB-justified)

This block turns a stream of stereo sample pairs (two 24-bit words) into a single serial data line. A frame is 64 bit clocks long and holds one 32-bit slot per channel. Word select is low for the left slot and high for the right slot. Two static inputs choose the framing and the bus role. With left-justified framing the MSB goes out on the same bit clock as the word select change. With I2S framing the MSB goes out one bit clock later. The remaining slot positions carry zeros. The output changes only on falling bit clock edges.

As bus master, the block divides its system clock to make the bit clock and word select itself. As slave, it brings an external bit clock and word select into the system clock domain through synchronizers. It tracks falling edges and keeps a predicted frame position, which any word select change realigns. A sample pair offered with a one-cycle strobe waits in a holding register until the next left slot begins. If no new pair has arrived by then, the previous pair is sent again. While power is off the block sits idle with all outputs low. After power comes on, the data line stays low for a fixed number of frames, so that upstream filtering can settle before real samples are sent.

Top module: `audio_ser_tx`

## Requirements
- R1: With `fmt_msbj`=0 (I2S), the sample MSB is sent at slot position 1, the bit clock after the word select change. Slot position 0 carries 0.
- R2: With `master_sel`=1 and `pwr_on`=1, `bclk_out` has a period of 2·BCLK_HALF system clocks. A frame is 64 bit clocks. `ws_out` is 0 for the 32 left positions and 1 for the 32 right positions, and changes only when `bclk_out` falls.
- R3: With `fmt_msbj`=1 (left-justified), the sample MSB is sent at slot position 0, together with the word select change. The 24 bits go out MSB first, and every slot position after the LSB is 0.
- R4: In master mode, `sd_out` changes only in the system clock cycle in which `bclk_out` falls.
- R5: With `master_sel`=0, `bclk_in` and `ws_in` are synchronized, and data advances one position per falling `bclk_in` edge. A change of `ws_in` seen at a rising edge moves the next position to 1 of the slot it selects (left for 0, right for 1). `bclk_out` and `ws_out` stay 0.
- R6: A pair given with `smp_valid` is sent from the next left slot start onward. With no new pair, the last pair repeats in every frame.
- R7: After `pwr_on` rises, `sd_out` is 0 through the first MUTE_FRAMES frames, counted from the first left-slot start. Samples appear from frame MUTE_FRAMES+1 onward.
- R8: While `pwr_on`=0, `sd_out`, `bclk_out` and `ws_out` are 0. The frame position and the mute count restart, so the next power-up mutes again.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| pwr_on | input | 1 | 1 = operate, 0 = power-down idle |
| master_sel | input | 1 | 1 = drive bit clock and word select, 0 = follow external ones |
| fmt_msbj | input | 1 | 1 = left-justified framing, 0 = I2S framing |
| smp_left | input | SAMPLE_W | Left sample, two's complement |
| smp_right | input | SAMPLE_W | Right sample, two's complement |
| smp_valid | input | 1 | One-cycle strobe that captures the sample pair |
| bclk_in | input | 1 | External bit clock (slave) |
| ws_in | input | 1 | External word select (slave) |
| bclk_out | output | 1 | Generated bit clock (master), 0 otherwise |
| ws_out | output | 1 | Generated word select (master), 0 otherwise |
| sd_out | output | 1 | Serial data |

## Verification
The hardest situation to reach is slave-mode realignment. An external word select edge arrives out of step with the block's predicted position, so the block must jump in mid-frame. Meanwhile a left-slot latch and the mute count must stay consistent across the jump. The bench plays the external master itself and cuts one frame short at position 40. It then checks that data lands on the restarted slot from the second bit on, and that sample latching and unmuting continue undisturbed. A power-down in the middle of a master-mode run is also driven, to show that muting starts over.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  // frame position: bit 5 selects the channel slot, bits 4:0 the bit inside it
  typedef logic [5:0] fpos_t;
  localparam fpos_t POS_IDLE = 6'd63;
endpackage

// File: rtl/bclk_divider.sv
// Bit clock generator for master role; rst_n is assumed already released
// synchronously to clk by the reset controller.
module bclk_divider #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic bclk,
  output logic fall_evt
);
  localparam int unsigned DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [DW-1:0] LAST = DW'(HALF_CYC - 1);

  logic [DW-1:0] div_q, div_d;
  logic          bclk_q, bclk_d;

  always_comb begin
    div_d    = div_q;
    bclk_d   = bclk_q;
    fall_evt = 1'b0;
    if (!run) begin
      div_d  = '0;
      bclk_d = 1'b0;
    end else if (div_q == LAST) begin
      div_d    = '0;
      bclk_d   = ~bclk_q;
      fall_evt = bclk_q;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk = bclk_q;
endmodule

// File: rtl/bus_edge_tracker.sv
// Slave role: synchronizes the external bit clock and word select, reports
// falling bit clock edges and word select changes captured on rising edges.
module bus_edge_tracker #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bclk_in,
  input  logic ws_in,
  output logic fall_evt,
  output logic restart,
  output logic ws_lvl
);
  logic [SYNC_STAGES:0]   bc_q, bc_d;
  logic [SYNC_STAGES-1:0] wsy_q, wsy_d;
  logic ws_cap_q, ws_cap_d, ws_prev_q, ws_prev_d;
  logic rise, fall;

  assign rise = bc_q[SYNC_STAGES-1] & ~bc_q[SYNC_STAGES];
  assign fall = ~bc_q[SYNC_STAGES-1] & bc_q[SYNC_STAGES];

  always_comb begin
    bc_d      = bc_q;
    wsy_d     = wsy_q;
    ws_cap_d  = ws_cap_q;
    ws_prev_d = ws_prev_q;
    if (!run) begin
      bc_d      = '0;
      wsy_d     = '0;
      ws_cap_d  = 1'b0;
      ws_prev_d = 1'b0;
    end else begin
      bc_d  = {bc_q[SYNC_STAGES-1:0], bclk_in};
      wsy_d = {wsy_q[SYNC_STAGES-2:0], ws_in};
      if (rise) ws_cap_d = wsy_q[SYNC_STAGES-1];
      if (fall) ws_prev_d = ws_cap_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q      <= '0;
      wsy_q     <= '0;
      ws_cap_q  <= 1'b0;
      ws_prev_q <= 1'b0;
    end else begin
      bc_q      <= bc_d;
      wsy_q     <= wsy_d;
      ws_cap_q  <= ws_cap_d;
      ws_prev_q <= ws_prev_d;
    end
  end

  assign fall_evt = run & fall;
  assign restart  = run & fall & (ws_cap_q != ws_prev_q);
  assign ws_lvl   = ws_cap_q;
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import audio_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned MUTE_FRAMES = 12288
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                fmt_msbj,
  input  logic                step,
  input  logic                restart,
  input  logic                restart_right,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                smp_valid,
  output logic                sd,
  output logic                ws
);
  localparam int unsigned   MW       = $clog2(MUTE_FRAMES + 2);
  localparam logic [MW-1:0] MUTE_END = MW'(MUTE_FRAMES);
  localparam logic [5:0]    W6       = 6'(SAMPLE_W);

  fpos_t               pos_q, pos_d;
  logic [SAMPLE_W-1:0] cur_l_q, cur_l_d, cur_r_q, cur_r_d;
  logic [SAMPLE_W-1:0] pend_l_q, pend_l_d, pend_r_q, pend_r_d;
  logic                pend_full_q, pend_full_d;
  logic [MW-1:0]       mcnt_q, mcnt_d;
  logic                live_q, live_d;
  logic                sd_q, sd_d, ws_q, ws_d;
  logic                left_start, in_range, bit_val;
  logic [4:0]          idx, shamt;
  logic [SAMPLE_W-1:0] word, shifted;

  always_comb begin
    pos_d = pos_q;
    if (!run)      pos_d = POS_IDLE;
    else if (step) pos_d = restart ? {restart_right, 5'd1} : pos_q + 1'b1;
    left_start = run & step & ~pos_d[5] & pos_q[5];
  end

  always_comb begin
    pend_l_d    = pend_l_q;
    pend_r_d    = pend_r_q;
    pend_full_d = pend_full_q;
    cur_l_d     = cur_l_q;
    cur_r_d     = cur_r_q;
    if (left_start && pend_full_q) begin
      cur_l_d = pend_l_q;
      cur_r_d = pend_r_q;
    end
    if (smp_valid) begin
      pend_l_d    = smp_left;
      pend_r_d    = smp_right;
      pend_full_d = 1'b1;
    end else if (left_start) begin
      pend_full_d = 1'b0;
    end
  end

  always_comb begin
    mcnt_d = mcnt_q;
    live_d = live_q;
    if (!run) begin
      mcnt_d = '0;
      live_d = 1'b0;
    end else if (left_start) begin
      if (mcnt_q == MUTE_END) live_d = 1'b1;
      else                    mcnt_d = mcnt_q + 1'b1;
    end
  end

  always_comb begin
    idx      = pos_d[4:0];
    shamt    = fmt_msbj ? idx : idx - 5'd1;
    in_range = fmt_msbj ? ({1'b0, idx} < W6) : ((idx != 5'd0) && ({1'b0, idx} <= W6));
    word     = pos_d[5] ? cur_r_d : cur_l_d;
    shifted  = word << shamt;
    bit_val  = shifted[SAMPLE_W-1] & in_range;
    sd_d     = sd_q;
    ws_d     = ws_q;
    if (!run) begin
      sd_d = 1'b0;
      ws_d = 1'b0;
    end else if (step) begin
      sd_d = live_d & bit_val;
      ws_d = pos_d[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q       <= POS_IDLE;
      cur_l_q     <= '0;
      cur_r_q     <= '0;
      pend_l_q    <= '0;
      pend_r_q    <= '0;
      pend_full_q <= 1'b0;
      mcnt_q      <= '0;
      live_q      <= 1'b0;
      sd_q        <= 1'b0;
      ws_q        <= 1'b0;
    end else begin
      pos_q       <= pos_d;
      cur_l_q     <= cur_l_d;
      cur_r_q     <= cur_r_d;
      pend_l_q    <= pend_l_d;
      pend_r_q    <= pend_r_d;
      pend_full_q <= pend_full_d;
      mcnt_q      <= mcnt_d;
      live_q      <= live_d;
      sd_q        <= sd_d;
      ws_q        <= ws_d;
    end
  end

  assign sd = sd_q;
  assign ws = ws_q;

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sd_q && !ws_q && pos_q == POS_IDLE && !live_q));

  // R3
  tail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_q |-> (fmt_msbj ? ({1'b0, pos_q[4:0]} < W6)
                       : (pos_q[4:0] != 5'd0 && {1'b0, pos_q[4:0]} <= W6)));

  // R7
  unmute_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live_q) |-> !pos_q[5]);
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import audio_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned BCLK_HALF   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MUTE_FRAMES = 12288
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_on,
  input  logic                master_sel,
  input  logic                fmt_msbj,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                smp_valid,
  input  logic                bclk_in,
  input  logic                ws_in,
  output logic                bclk_out,
  output logic                ws_out,
  output logic                sd_out
);
  logic m_run, s_run, m_bclk, m_fall, s_fall, s_restart, s_ws;
  logic step, restart, ser_sd, ser_ws;

  assign m_run = pwr_on & master_sel;
  assign s_run = pwr_on & ~master_sel;

  bclk_divider #(.HALF_CYC(BCLK_HALF)) i_div (
    .clk(clk), .rst_n(rst_n), .run(m_run), .bclk(m_bclk), .fall_evt(m_fall)
  );

  bus_edge_tracker #(.SYNC_STAGES(SYNC_STAGES)) i_trk (
    .clk(clk), .rst_n(rst_n), .run(s_run), .bclk_in(bclk_in), .ws_in(ws_in),
    .fall_evt(s_fall), .restart(s_restart), .ws_lvl(s_ws)
  );

  assign step    = master_sel ? m_fall : s_fall;
  assign restart = ~master_sel & s_restart;

  frame_serializer #(.SAMPLE_W(SAMPLE_W), .MUTE_FRAMES(MUTE_FRAMES)) i_ser (
    .clk(clk), .rst_n(rst_n), .run(pwr_on), .fmt_msbj(fmt_msbj),
    .step(step), .restart(restart), .restart_right(s_ws),
    .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid),
    .sd(ser_sd), .ws(ser_ws)
  );

  assign bclk_out = m_bclk;
  assign ws_out   = master_sel & ser_ws;
  assign sd_out   = ser_sd;

  // R4
  sd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_on) && $past(master_sel) && sd_out != $past(sd_out))
      |-> ($past(bclk_out) && !bclk_out));

  // R2
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_on) && $past(master_sel) && ws_out != $past(ws_out))
      |-> ($past(bclk_out) && !bclk_out));

  // R5
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(master_sel) |-> !bclk_out);
endmodule

// File: tb/test_audio_ser_tx.sv
`timescale 1ns/1ps
module test_audio_ser_tx;
  localparam int W  = 24;
  localparam int H  = 2;
  localparam int N  = 3;
  localparam int SH = 8;
  localparam int FR = 64 * 2 * H;

  logic clk = 1'b0;
  logic rst_n, pwr_on, master_sel, fmt_msbj, smp_valid, bclk_in, ws_in;
  logic [W-1:0] smp_left, smp_right;
  logic bclk_out, ws_out, sd_out;

  audio_ser_tx #(.SAMPLE_W(W), .BCLK_HALF(H), .SYNC_STAGES(2), .MUTE_FRAMES(N)) i_audio_ser_tx (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .master_sel(master_sel), .fmt_msbj(fmt_msbj),
    .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid),
    .bclk_in(bclk_in), .ws_in(ws_in), .bclk_out(bclk_out), .ws_out(ws_out), .sd_out(sd_out)
  );

  always #5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0, cmp_en = 0;
  string ph = "R9";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic exp_bit(input int p, input logic msbj, input logic [W-1:0] l, input logic [W-1:0] r);
    int s, k;
    logic [W-1:0] w;
    s = p % 32;
    k = msbj ? s : s - 1;
    w = (p >= 32) ? r : l;
    if (k >= 0 && k < W) return w[W-1-k];
    return 1'b0;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [W-1:0] l, input logic [W-1:0] r);
    smp_left = l; smp_right = r; smp_valid = 1'b1;
    tick(1);
    smp_valid = 1'b0;
  endtask

  // master-mode reference model, updated at each rising edge
  int m_div, m_pos, m_mcnt;
  logic m_bclk, m_ws, m_sd, m_live, m_on, m_full;
  logic [W-1:0] m_cl, m_cr, m_pl, m_pr;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_div = 0; m_bclk = 0; m_pos = 63; m_ws = 0; m_sd = 0; m_mcnt = 0; m_live = 0; m_on = 0;
      m_cl = '0; m_cr = '0; m_pl = '0; m_pr = '0; m_full = 0;
    end else begin
      m_on = pwr_on && master_sel;
      if (!m_on) begin
        m_div = 0; m_bclk = 0; m_pos = 63; m_ws = 0; m_sd = 0; m_mcnt = 0; m_live = 0;
      end else if (m_div == H - 1) begin
        m_div = 0;
        if (m_bclk) begin
          int np;
          m_bclk = 0;
          np = (m_pos + 1) % 64;
          if (np < 32 && m_pos >= 32) begin
            if (m_full) begin m_cl = m_pl; m_cr = m_pr; m_full = 0; end
            if (m_mcnt == N) m_live = 1; else m_mcnt++;
          end
          m_pos = np;
          m_ws  = (np >= 32);
          m_sd  = m_live ? exp_bit(np, fmt_msbj, m_cl, m_cr) : 1'b0;
        end else begin
          m_bclk = 1;
        end
      end else begin
        m_div++;
      end
      if (smp_valid) begin m_pl = smp_left; m_pr = smp_right; m_full = 1; end
    end
  end

  // per-clock comparison in master mode
  logic prev_sd, prev_bclk, prev_ws, prev_on;
  int last_rise = -1, nfall = 0;
  bit nfall_ok = 0;
  initial begin prev_sd = 0; prev_bclk = 0; prev_ws = 0; prev_on = 0; end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(bclk_out === m_bclk, "R2", "bclk_out", bclk_out, m_bclk);
      chk(ws_out === m_ws, (m_on ? "R2" : ph), "ws_out", ws_out, m_ws);
      chk(sd_out === m_sd, (m_live ? ph : "R7"), "sd_out", sd_out, m_sd);
      if (m_on && prev_on) begin
        if (sd_out !== prev_sd)
          chk(prev_bclk === 1'b1 && bclk_out === 1'b0, "R4", "sd change off falling edge", bclk_out, 0);
        if (bclk_out && !prev_bclk) begin
          if (last_rise >= 0) chk(cyc - last_rise == 2 * H, "R2", "bit clock period", cyc - last_rise, 2 * H);
          last_rise = cyc;
        end
        if (!bclk_out && prev_bclk) nfall++;
        if (ws_out && !prev_ws) begin
          if (nfall_ok) chk(nfall == 64, "R2", "bit clocks per frame", nfall, 64);
          nfall = 0; nfall_ok = 1;
        end
      end else begin
        last_rise = -1; nfall = 0; nfall_ok = 0;
      end
    end
    prev_sd = sd_out; prev_bclk = bclk_out; prev_ws = ws_out; prev_on = m_on;
  end

  // slave-mode stimulus and expectation
  task automatic run_slave(input int nbits, input int jump_b, input logic [W-1:0] ql[2], input logic [W-1:0] qr[2],
                           input logic [W-1:0] pl0, input logic [W-1:0] pr0);
    int p = 0, fc = 0, qi = 0;
    bit jumped = 0, s_full = 1;
    logic [W-1:0] cl = '0, cr = '0, pl = pl0, pr = pr0;
    logic e;
    bclk_in = 1'b1; ws_in = 1'b0;
    tick(SH);
    for (int b = 0; b < nbits; b++) begin
      bclk_in = 1'b0;
      ws_in = (p >= 32);
      if (p == 0) begin
        fc++;
        if (s_full) begin cl = pl; cr = pr; s_full = 0; end
      end
      e = (fc > N) ? exp_bit(p, fmt_msbj, cl, cr) : 1'b0;
      if (p == 40 && qi < 2) begin
        smp_left = ql[qi]; smp_right = qr[qi]; smp_valid = 1'b1;
        pl = ql[qi]; pr = qr[qi]; s_full = 1; qi++;
        tick(1);
        smp_valid = 1'b0;
        tick(SH - 2);
      end else begin
        tick(SH - 1);
      end
      @(negedge clk);
      if (!jumped) chk(sd_out === e, (fc > N) ? "R5" : "R7", "slave sd_out", sd_out, e);
      chk(bclk_out === 1'b0 && ws_out === 1'b0, "R5", "slave outputs quiet", bclk_out + ws_out, 0);
      tick(1);
      bclk_in = 1'b1;
      tick(SH - 1);
      jumped = (b == jump_b);
      p = jumped ? 0 : (p + 1) % 64;
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    if (!done && cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ql[2], qr[2];
    rst_n = 0; pwr_on = 0; master_sel = 1; fmt_msbj = 1; smp_valid = 0;
    smp_left = '0; smp_right = '0; bclk_in = 0; ws_in = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(sd_out === 1'b0 && bclk_out === 1'b0 && ws_out === 1'b0, "R9", "outputs in reset",
          sd_out + bclk_out + ws_out, 0);
    end
    tick(1);
    cmp_en = 1;
    rst_n = 1;
    tick(2);

    // left-justified master, mute then data, new pair mid-run
    ph = "R3";
    push(24'hC3A5F1, 24'h5A0F3C);
    pwr_on = 1;
    tick(FR * 6 + 37);
    push(24'h800001, 24'hFFFFFF);
    tick(FR * 2);

    // no new pairs: last pair repeats
    ph = "R6";
    tick(FR * 3);

    // power-down mid-frame, then mute starts over
    ph = "R8";
    pwr_on = 0;
    tick(3);
    @(negedge clk);
    chk(sd_out === 1'b0 && bclk_out === 1'b0 && ws_out === 1'b0, "R8", "outputs in power-down",
        sd_out + bclk_out + ws_out, 0);
    tick(20);
    pwr_on = 1;
    tick(FR * 6);

    // I2S framing, master
    ph = "R1";
    pwr_on = 0;
    tick(2);
    rst_n = 0;
    tick(2);
    rst_n = 1;
    fmt_msbj = 0;
    push(24'h123456, 24'hFEDCBA);
    pwr_on = 1;
    tick(FR * 7);

    // slave role with a mid-frame word select jump
    ph = "R5";
    cmp_en = 0;
    pwr_on = 0;
    tick(2);
    rst_n = 0;
    master_sel = 0;
    fmt_msbj = 1;
    tick(2);
    rst_n = 1;
    push(24'hA0B1C2, 24'h0F1E2D);
    pwr_on = 1;
    tick(4);
    ql[0] = 24'h7FFFFF; qr[0] = 24'h800000;
    ql[1] = 24'h2468AC; qr[1] = 24'hDB9753;
    run_slave(64 * 9, 64 * 5 + 40, ql, qr, 24'hA0B1C2, 24'h0F1E2D);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule